// File: doc/BRIEF.md
# Dual-Mode Flash Read Port

This block models the read side of a NOR-style flash device behind one pin-level bus. The same pins serve two kinds of read. An asynchronous page read latches a page address and then returns any word of that aligned 4-word page as the low address bits change. A clock-synchronous burst read latches a start address and advances one word on each selected flash-clock edge. A small command decoder decides whether the bus returns array words or the status byte. A configuration value, loaded by a two-write command sequence, picks the read mode, the burst length and the active clock edge.

All pins are sampled by the system clock `clk`. The flash clock `fclk` is treated as a sampled data signal, so its edges are detected inside the block rather than used as a clock. The array is read-only, and its contents are computed from the word address. A power-save flag shows when the port is idle between accesses. The tri-state data bus is modelled as an output word plus an output-enable.

Top module: `flash_read_port`

## Requirements
- R1: After reset the port is in asynchronous page mode with array reads selected, so array data is returned without any prior command. The configuration selects asynchronous mode, 4-word length and the rising edge.
- R2: `dataOe` is 1 only while `ceN` and `oeN` are both low. Whenever `dataOe` is 0, `dataOut` is 0.
- R3: The array word at address a is (a * 0x9E37 + 0x1234) mod 2^16.
- R4: In asynchronous mode the page is captured on a rising edge of `advN` while `ceN` is low. The word returned is at address {captured address[AW-1:2], live address[1:0]}. Later changes to the upper address bits are ignored.
- R5: In asynchronous mode, toggling `fclk` has no effect on the returned word.
- R6: A command is accepted on a rising edge of `weN` while `ceN` is low, with its code on `cmdData`. 0xFF selects array reads and 0x70 selects status reads.
- R7: While status reads are selected, `dataOut` = {8'h00, status}. Status bit 7 is always 1. Status bit 4 is a sticky sequence-error flag, and all other status bits are 0. Any command other than 0xFF, including an unknown code, leaves status reads selected until 0xFF is written.
- R8: A write of 0x60 followed by a write of 0x03 loads the configuration from `addr[3:0]` of the second write. Bit 0 selects synchronous burst mode. Bits 2:1 select the length: 00 gives 4 words, 01 gives 8 words, and 1x gives a continuous burst. Bit 3 selects the falling edge. If 0x60 is followed by any other code, the configuration is left unchanged and status bit 4 is set.
- R9: In synchronous mode a rising edge of `advN` with `ceN` low loads the burst start address, and the first word is the word at that address. Each selected `fclk` edge with `ceN` low and `advN` high advances the burst by one word.
- R10: A 4-word burst wraps within its aligned 4-word group, and an 8-word burst wraps within its aligned 8-word group.
- R11: A continuous burst increments linearly and wraps from the top address to 0.
- R12: Only the configured `fclk` edge advances a burst. The opposite edge has no effect.
- R13: While `ceN` is high the burst does not advance and the bus is not driven. A later access resumes at the held word, and a new `advN` rising edge restarts the burst.
- R14: `apsIdle` is 1 after reset. It falls when `advN` and `ceN` are both low. It rises again once an array read, during which `oeN` was low, ends with `ceN` or `oeN` going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| advN | input | 1 | Address-valid strobe, active low; its rising edge latches the address |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low; its rising edge accepts a command |
| fclk | input | 1 | Flash burst clock, sampled as data |
| addr | input | AW | Word address; also carries the configuration value |
| cmdData | input | 8 | Command byte lane of the data bus |
| dataOut | output | 16 | Read data |
| dataOe | output | 1 | Read data drive enable |
| apsIdle | output | 1 | Automatic power-save idle flag |

## Verification
The bench goes after the group-wrap boundaries: a 4-word burst started at offset 2 and an 8-word burst started at offset 5 must fold back inside their groups, while a continuous burst started at 0xFE must cross 0xFF into 0x00. A design that carries into the upper address bits would return words from the next group. It toggles `fclk` in asynchronous mode and checks the opposite edge in burst mode; a design that honours every edge would skip words. It sends a bad configuration sequence, checks that the configuration is unchanged, and checks that status reads persist until 0xFF is written; a design that falls back to array reads on its own would show array words in place of the status byte. Finally it suspends a burst with `ceN` high while clocking, to catch a counter that keeps running when the chip is deselected.

// File: rtl/frp_pkg.sv
`timescale 1ns/1ps
package frp_pkg;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CFG_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CFG_CONFIRM = 8'h03;

  localparam logic [1:0] LEN_FOUR  = 2'b00;
  localparam logic [1:0] LEN_EIGHT = 2'b01;

  typedef struct packed {
    logic       syncMode;
    logic [1:0] burstLen;
    logic       fallEdge;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{syncMode: 1'b0, burstLen: LEN_FOUR, fallEdge: 1'b0};

  // strobes from control to datapath
  typedef struct packed {
    logic       advRise;
    logic       stepBurst;
    logic       driveBus;
    logic       showStatus;
    logic       syncMode;
    logic [1:0] burstLen;
  } strobes_t;

  function automatic logic [15:0] arrayWord(input logic [15:0] wordAddr);
    return (wordAddr * 16'h9E37) + 16'h1234;
  endfunction

endpackage

// File: rtl/frp_ctrl.sv
`timescale 1ns/1ps
module frp_ctrl
  import frp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          advN,
  input  logic          ceN,
  input  logic          oeN,
  input  logic          weN,
  input  logic          fclk,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    cmdData,
  output strobes_t      st,
  output logic [AW-1:0] sAddr,
  output logic [7:0]    statusByte,
  output logic          apsIdle
);

  // sampled pins and their previous values
  logic sCe, sOe, sWe, sAdv, sFclk;
  logic sWeD, sAdvD, sFclkD;
  logic [7:0] sCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sCe    <= 1'b1;
      sOe    <= 1'b1;
      sWe    <= 1'b1;
      sAdv   <= 1'b1;
      sFclk  <= 1'b0;
      sWeD   <= 1'b1;
      sAdvD  <= 1'b1;
      sFclkD <= 1'b0;
      sAddr  <= '0;
      sCmd   <= '0;
    end else begin
      sCe    <= ceN;
      sOe    <= oeN;
      sWe    <= weN;
      sAdv   <= advN;
      sFclk  <= fclk;
      sWeD   <= sWe;
      sAdvD  <= sAdv;
      sFclkD <= sFclk;
      sAddr  <= addr;
      sCmd   <= cmdData;
    end
  end

  logic cmdStrobe, advRise, clkRise, clkFall;
  assign cmdStrobe = sWe && !sWeD && !sCe;
  assign advRise   = sAdv && !sAdvD && !sCe;
  assign clkRise   = sFclk && !sFclkD;
  assign clkFall   = !sFclk && sFclkD;

  // command decoder state
  cfg_t cfgReg;
  logic readArr, cfgPending, seqErr, cfgLoad;

  assign cfgLoad = cmdStrobe && cfgPending && (sCmd == CMD_CFG_CONFIRM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg     <= CFG_RESET;
      readArr    <= 1'b1;
      cfgPending <= 1'b0;
      seqErr     <= 1'b0;
    end else if (cmdStrobe) begin
      if (cfgPending) begin
        cfgPending <= 1'b0;
        readArr    <= 1'b0;
        if (sCmd == CMD_CFG_CONFIRM) begin
          cfgReg <= '{syncMode: sAddr[0], burstLen: sAddr[2:1], fallEdge: sAddr[3]};
        end else begin
          seqErr <= 1'b1;
        end
      end else begin
        unique case (sCmd)
          CMD_READ_ARRAY:  readArr <= 1'b1;
          CMD_READ_STATUS: readArr <= 1'b0;
          CMD_CFG_SETUP: begin
            readArr    <= 1'b0;
            cfgPending <= 1'b1;
          end
          default:         readArr <= 1'b0;
        endcase
      end
    end
  end

  assign statusByte = {1'b1, 2'b00, seqErr, 4'b0000};

  // power-save tracking
  logic readSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      apsIdle  <= 1'b1;
      readSeen <= 1'b0;
    end else if (!sCe && !sAdv) begin
      apsIdle  <= 1'b0;
      readSeen <= 1'b0;
    end else if (!apsIdle && !sCe && !sOe && readArr) begin
      readSeen <= 1'b1;
    end else if (readSeen && (sCe || sOe)) begin
      apsIdle  <= 1'b1;
      readSeen <= 1'b0;
    end
  end

  logic edgeHit;
  assign edgeHit = cfgReg.fallEdge ? clkFall : clkRise;

  always_comb begin
    st.advRise    = advRise;
    st.stepBurst  = cfgReg.syncMode && !sCe && sAdv && edgeHit;
    st.driveBus   = !sCe && !sOe;
    st.showStatus = !readArr;
    st.syncMode   = cfgReg.syncMode;
    st.burstLen   = cfgReg.burstLen;
  end

  // R8: configuration changes only on a completed setup/confirm pair
  p_cfg_by_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg != $past(cfgReg)) |-> $past(cfgLoad));

  // R7: sequence error is sticky
  p_seqerr_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(seqErr) |-> seqErr);

  // R14: power-save is re-entered only after a read was seen
  p_aps_after_read_r14: assert property (@(posedge clk) disable iff (!rstN)
    $rose(apsIdle) |-> $past(readSeen));

endmodule

// File: rtl/frp_data.sv
`timescale 1ns/1ps
module frp_data
  import frp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic [AW-1:0] sAddr,
  input  logic [7:0]    statusByte,
  output logic [15:0]   dataOut,
  output logic          dataOe
);

  localparam int PW = AW - 2;

  logic [PW-1:0] pageBase;
  logic [AW-1:0] burstAddr, burstNext, rdAddr;

  always_comb begin
    if (st.burstLen == LEN_FOUR)
      burstNext = {burstAddr[AW-1:2], burstAddr[1:0] + 2'd1};
    else if (st.burstLen == LEN_EIGHT)
      burstNext = {burstAddr[AW-1:3], burstAddr[2:0] + 3'd1};
    else
      burstNext = burstAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageBase  <= '0;
      burstAddr <= '0;
    end else if (st.advRise) begin
      pageBase  <= sAddr[AW-1:2];
      burstAddr <= sAddr;
    end else if (st.stepBurst) begin
      burstAddr <= burstNext;
    end
  end

  assign rdAddr = st.syncMode ? burstAddr : {pageBase, sAddr[1:0]};

  always_comb begin
    dataOe = st.driveBus;
    if (!st.driveBus)
      dataOut = '0;
    else if (st.showStatus)
      dataOut = {8'h00, statusByte};
    else
      dataOut = arrayWord(16'(rdAddr));
  end

  // R13: burst address holds without a step or a new start
  p_burst_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!st.stepBurst && !st.advRise) |=> $stable(burstAddr));

  // R10: a 4-word step never leaves its group
  p_wrap_four_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepBurst && !st.advRise && st.burstLen == LEN_FOUR)
      |=> burstAddr[AW-1:2] == $past(burstAddr[AW-1:2]));

  // R10: an 8-word step never leaves its group
  p_wrap_eight_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepBurst && !st.advRise && st.burstLen == LEN_EIGHT)
      |=> burstAddr[AW-1:3] == $past(burstAddr[AW-1:3]));

endmodule

// File: rtl/flash_read_port.sv
`timescale 1ns/1ps
module flash_read_port
  import frp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          advN,
  input  logic          ceN,
  input  logic          oeN,
  input  logic          weN,
  input  logic          fclk,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    cmdData,
  output logic [15:0]   dataOut,
  output logic          dataOe,
  output logic          apsIdle
);

  strobes_t      st;
  logic [AW-1:0] sAddr;
  logic [7:0]    statusByte;

  frp_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .advN(advN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .fclk(fclk), .addr(addr), .cmdData(cmdData),
    .st(st), .sAddr(sAddr), .statusByte(statusByte), .apsIdle(apsIdle)
  );

  frp_data #(.AW(AW)) uData (
    .clk(clk), .rstN(rstN), .st(st), .sAddr(sAddr), .statusByte(statusByte),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // R2: no drive while deselected, and a quiet bus when not driven
  p_bus_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == 16'h0000);

endmodule

// File: tb/sim_flash_read_port.sv
`timescale 1ns/1ps
module sim_flash_read_port;

  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advN = 1'b1, ceN = 1'b1, oeN = 1'b1, weN = 1'b1, fclk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] cmdData = '0;
  logic [15:0] dataOut;
  logic dataOe, apsIdle;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_read_port #(.AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .advN(advN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .fclk(fclk), .addr(addr), .cmdData(cmdData),
    .dataOut(dataOut), .dataOe(dataOe), .apsIdle(apsIdle)
  );

  function automatic logic [15:0] expWord(input logic [AW-1:0] a);
    logic [15:0] w;
    w = 16'(a);
    return w * 16'h9E37 + 16'h1234;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkWord(input string tag, input logic [15:0] exp);
    chk(dataOe && dataOut == exp, tag, dataOut, exp);
  endtask

  task automatic sendCmd(input logic [7:0] code, input logic [AW-1:0] a);
    ceN = 1'b0; addr = a; cmdData = code; weN = 1'b0; tick(2);
    weN = 1'b1; tick(2);
    ceN = 1'b1; tick(2);
  endtask

  task automatic startAccess(input logic [AW-1:0] a);
    ceN = 1'b0; addr = a; advN = 1'b0; tick(2);
    advN = 1'b1; tick(2);
  endtask

  task automatic endAccess();
    oeN = 1'b1; ceN = 1'b1; tick(3);
  endtask

  task automatic flipClk();
    fclk = ~fclk; tick(3);
  endtask

  task automatic setCfg(input logic [3:0] v);
    sendCmd(8'h60, AW'(0));
    sendCmd(8'h03, AW'(v));
    sendCmd(8'hFF, AW'(0));
  endtask

  task automatic t_reset();
    chk(dataOe == 1'b0, "R2 idle bus after reset", 16'(dataOe), 16'h0);
    chk(apsIdle == 1'b1, "R14 power-save after reset", 16'(apsIdle), 16'h1);
  endtask

  task automatic t_async_page();
    startAccess(8'h37);
    chk(apsIdle == 1'b0, "R14 power-save left on access", 16'(apsIdle), 16'h0);
    oeN = 1'b0; tick(3);
    chkWord("R1 R3 array read without command", expWord(8'h37));
    for (int k = 0; k < 4; k++) begin
      addr = {~6'(8'h37 >> 2), 2'(k)}; tick(3);
      chkWord("R4 page word from latched base", expWord({6'(8'h37 >> 2), 2'(k)}));
    end
    oeN = 1'b1; tick(3);
    chk(apsIdle == 1'b1, "R14 power-save after read", 16'(apsIdle), 16'h1);
    chk(dataOe == 1'b0 && dataOut == 16'h0, "R2 no drive with oeN high", dataOut, 16'h0);
    endAccess();
  endtask

  task automatic t_clk_ignored();
    startAccess(8'h52);
    oeN = 1'b0; tick(3);
    for (int k = 0; k < 4; k++) begin
      flipClk();
      chkWord("R5 fclk ignored in async mode", expWord(8'h52));
    end
    endAccess();
  endtask

  task automatic t_bus_enable();
    ceN = 1'b0; oeN = 1'b1; tick(3);
    chk(!dataOe && dataOut == 16'h0, "R2 ceN low oeN high", dataOut, 16'h0);
    ceN = 1'b1; oeN = 1'b0; tick(3);
    chk(!dataOe && dataOut == 16'h0, "R2 ceN high oeN low", dataOut, 16'h0);
    oeN = 1'b1; tick(2);
  endtask

  task automatic t_status();
    sendCmd(8'h70, 8'h00);
    startAccess(8'h21); oeN = 1'b0; tick(3);
    chkWord("R6 R7 status read", 16'h0080);
    endAccess();
    sendCmd(8'hFF, 8'h00);
    startAccess(8'h21); oeN = 1'b0; tick(3);
    chkWord("R6 array after read-array", expWord(8'h21));
    endAccess();
  endtask

  task automatic t_bad_sequence();
    sendCmd(8'h60, 8'h00);
    sendCmd(8'h55, 8'h01);
    startAccess(8'h0C); oeN = 1'b0; tick(3);
    chkWord("R7 R8 sequence error flagged", 16'h0090);
    endAccess();
    sendCmd(8'hFF, 8'h00);
    startAccess(8'h0C); oeN = 1'b0; tick(3);
    flipClk(); flipClk();
    chkWord("R8 config unchanged after bad sequence", expWord(8'h0C));
    endAccess();
    sendCmd(8'h20, 8'h00);
    startAccess(8'h0C); oeN = 1'b0; tick(3);
    chkWord("R7 unknown command selects status", 16'h0090);
    endAccess();
    sendCmd(8'hFF, 8'h00);
  endtask

  task automatic runBurst(input string tag, input logic [AW-1:0] start,
                          input int span, input int steps);
    logic [AW-1:0] cur;
    cur = start;
    startAccess(start); oeN = 1'b0; tick(3);
    chkWord({"R9 first word ", tag}, expWord(cur));
    for (int k = 0; k < steps; k++) begin
      flipClk();
      if (span == 4)      cur = {cur[AW-1:2], cur[1:0] + 2'd1};
      else if (span == 8) cur = {cur[AW-1:3], cur[2:0] + 3'd1};
      else                cur = cur + 1'b1;
      chkWord({"R9 R10 R11 step ", tag}, expWord(cur));
      flipClk();
      chkWord({"R12 opposite edge holds ", tag}, expWord(cur));
    end
    endAccess();
  endtask

  task automatic t_bursts();
    setCfg(4'b0001);
    runBurst("four", 8'h46, 4, 4);
    setCfg(4'b0011);
    runBurst("eight", 8'h2D, 8, 5);
    setCfg(4'b0101);
    runBurst("cont", 8'hFE, 0, 3);
  endtask

  task automatic t_fall_and_cut();
    setCfg(4'b1001);
    startAccess(8'h10); oeN = 1'b0; tick(3);
    flipClk();
    chkWord("R12 rising edge ignored", expWord(8'h10));
    flipClk();
    chkWord("R12 falling edge advances", expWord(8'h11));
    ceN = 1'b1; tick(3);
    chk(!dataOe, "R13 no drive while deselected", 16'(dataOe), 16'h0);
    for (int k = 0; k < 4; k++) flipClk();
    ceN = 1'b0; tick(3);
    chkWord("R13 burst held while deselected", expWord(8'h11));
    endAccess();
    startAccess(8'h80); oeN = 1'b0; tick(3);
    chkWord("R13 new start restarts burst", expWord(8'h80));
    endAccess();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(3);
    t_reset();
    t_async_page();
    t_clk_ignored();
    t_bus_enable();
    t_status();
    t_bad_sequence();
    t_bursts();
    t_fall_and_cut();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule